// File: doc/BRIEF.md
# PWM-Period Interrupt Rate Divider

This block lowers the rate of interrupt requests raised by a motor-control PWM carrier. It counts PWM-period events and emits a one-cycle interrupt pulse once per programmed number of events. The events come from one of two sources. The first is the underflow pulse of the carrier timer. The second is a chosen edge of a reload-control level produced by a companion timer.

Software programs the block through a narrow write port that has two targets. One target holds the divide value n. The other holds three control bits: mode, source select and edge polarity. A per-block enable gates the counting.

The first interrupt after a new divide value arrives one event early. This lets the interrupt line up with the carrier phase. After that first interrupt, interrupts come every n events.

Top module: `pwm_irq_divider`

## Requirements
- R1: After reset, `irq_pulse` is 0, all three control bits are 0, the divide value is 0 and the event count is 0.
- R2: With mode bit 0, one event is counted for every cycle in which `carrier_unf` is 1. In this mode the source-select bit, the polarity bit and `reload_sig` have no effect.
- R3: With mode bit 1 and source-select bit 1, events come only from edges of `reload_sig`, and `carrier_unf` is ignored. With mode bit 1 and source-select bit 0, events come from `carrier_unf` as in R2.
- R4: The polarity bit picks which edge of `reload_sig` is counted. A value of 0 counts a 0-to-1 change and a value of 1 counts a 1-to-0 change, judged between consecutive clock edges, so each change counts once.
- R5: With divide value n ≥ 2, the first interrupt after reset or after a divide write comes on the (n-1)-th event. Every later interrupt comes on each n-th event after it.
- R6: A divide value of 0 behaves as 1. With an effective value of 1, every event raises an interrupt.
- R7: A divide write has `wr_en`=1 and `wr_sel`=0, with n on `wr_data`. An accepted divide write clears the event count and restarts the first-interrupt rule of R5. An event in the same cycle as the write is not counted.
- R8: While the source-select bit is 1, divide writes are ignored. The stored value, the count and the first-interrupt state stay unchanged. A control write has `wr_en`=1 and `wr_sel`=1, with mode on `wr_data[0]`, source select on `wr_data[1]` and polarity on `wr_data[2]`. Control writes are always accepted.
- R9: While `func_en` is 0, no event is counted, the count is held and `irq_pulse` stays 0. Reload edges that occur while disabled are never counted later.
- R10: `irq_pulse` is high for exactly the one cycle that follows the clock edge at which the completing event is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| func_en | input | 1 | Enables event counting |
| carrier_unf | input | 1 | Carrier-timer underflow pulse |
| reload_sig | input | 1 | Reload-control level of the companion timer |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 divide value, 1 control bits |
| wr_data | input | DIV_W | Write data |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
Every result has one cycle of latency. An event sampled at clock edge k, whether an underflow or a reload edge, shows up on `irq_pulse` in the cycle after edge k. A register write sampled at edge k governs the events sampled from edge k+1 onward.

The bench drives its inputs on the falling edge. It advances a reference model by one step for those inputs, and compares `irq_pulse` with the model's prediction at the next falling edge. Every cycle is compared in this way, so both a missing pulse and a pulse that lasts too long are caught in the cycle where they occur.

// File: rtl/pid_pkg.sv
package pid_pkg;

    // Control bits; wr_data[0]=mode, [1]=src, [2]=pol.
    typedef struct packed {
        logic pol;
        logic src;
        logic mode;
    } ctl_t;

    localparam int CTL_W = 3;

endpackage

// File: rtl/pid_config_regs.sv
module pid_config_regs #(
    parameter int DIV_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [DIV_W-1:0]     wr_data,
    output pid_pkg::ctl_t        ctl,
    output logic [DIV_W-1:0]     div_val,
    output logic                 div_restart
);
    import pid_pkg::*;

    typedef struct packed {
        ctl_t             ctl;
        logic [DIV_W-1:0] div;
    } cfg_state_t;

    cfg_state_t s_d, s_q;
    logic       div_wr_d;
    logic       ctl_wr_d;

    always_comb begin
        s_d      = s_q;
        div_wr_d = wr_en && !wr_sel && !s_q.ctl.src;
        ctl_wr_d = wr_en && wr_sel;
        if (div_wr_d) begin
            s_d.div = wr_data;
        end
        if (ctl_wr_d) begin
            s_d.ctl.mode = wr_data[0];
            s_d.ctl.src  = wr_data[1];
            s_d.ctl.pol  = wr_data[2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctl         = s_q.ctl;
    assign div_val     = s_q.div;
    assign div_restart = div_wr_d;

    AST_SRC_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && s_q.ctl.src) |=> $stable(s_q.div)); // R8

endmodule

// File: rtl/pid_event_select.sv
module pid_event_select (
    input  logic          clk,
    input  logic          rst_n,
    input  pid_pkg::ctl_t ctl,
    input  logic          run,
    input  logic          carrier_unf,
    input  logic          reload_sig,
    output logic          evt
);
    import pid_pkg::*;

    typedef struct packed {
        logic rel;
    } sel_state_t;

    sel_state_t s_d, s_q;
    logic       rise_d;
    logic       fall_d;
    logic       edge_hit_d;
    logic       use_reload_d;

    always_comb begin
        s_d          = s_q;
        s_d.rel      = reload_sig;
        rise_d       = reload_sig && !s_q.rel;
        fall_d       = !reload_sig && s_q.rel;
        edge_hit_d   = ctl.pol ? fall_d : rise_d;
        use_reload_d = ctl.mode && ctl.src;
        if (!run) begin
            evt = 1'b0;
        end else if (use_reload_d) begin
            evt = edge_hit_d;
        end else begin
            evt = carrier_unf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/pid_rate_counter.sv
module pid_rate_counter #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_val,
    output logic             irq
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             first;
        logic             irq;
    } cnt_state_t;

    cnt_state_t       s_d, s_q;
    logic [DIV_W-1:0] eff_n;
    logic [DIV_W-1:0] thr;
    logic [DIV_W:0]   cnt_nx;

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        eff_n   = (div_val == '0) ? ONE : div_val;
        thr     = (s_q.first && (eff_n > ONE)) ? (eff_n - ONE) : eff_n;
        cnt_nx  = {1'b0, s_q.cnt} + {{DIV_W{1'b0}}, 1'b1};
        if (restart) begin
            s_d.cnt   = '0;
            s_d.first = 1'b1;
        end else if (evt) begin
            if (cnt_nx >= {1'b0, thr}) begin
                s_d.irq   = 1'b1;
                s_d.cnt   = '0;
                s_d.first = 1'b0;
            end else begin
                s_d.cnt = cnt_nx[DIV_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cnt: '0, first: 1'b1, irq: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign irq = s_q.irq;

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < eff_n); // R5
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (s_q.cnt == '0 && s_q.first)); // R7
    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> !s_q.irq); // R10

endmodule

// File: rtl/pwm_irq_divider.sv
module pwm_irq_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             func_en,
    input  logic             carrier_unf,
    input  logic             reload_sig,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [DIV_W-1:0] wr_data,
    output logic             irq_pulse
);
    import pid_pkg::*;

    ctl_t             ctl;
    logic [DIV_W-1:0] div_val;
    logic             div_restart;
    logic             evt;

    pid_config_regs #(.DIV_W(DIV_W)) cfg_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .ctl         (ctl),
        .div_val     (div_val),
        .div_restart (div_restart)
    );

    pid_event_select sel_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl         (ctl),
        .run         (func_en),
        .carrier_unf (carrier_unf),
        .reload_sig  (reload_sig),
        .evt         (evt)
    );

    pid_rate_counter #(.DIV_W(DIV_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .restart (div_restart),
        .div_val (div_val),
        .irq     (irq_pulse)
    );

    AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !func_en |=> !irq_pulse); // R9
    AST_BASIC_NO_UNF_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.mode && !carrier_unf) |=> !irq_pulse); // R2

endmodule

// File: tb/pwm_irq_divider_tb_top.sv
`timescale 1ns/100ps
module pwm_irq_divider_tb_top;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             func_en = 1'b0;
    logic             carrier_unf = 1'b0;
    logic             reload_sig = 1'b0;
    logic             wr_en = 1'b0;
    logic             wr_sel = 1'b0;
    logic [DIV_W-1:0] wr_data = '0;
    logic             irq_pulse;

    int    checks = 0;
    int    fails = 0;
    string cur_req = "R1";
    bit    done = 0;
    bit    rel_lvl = 0;

    // reference model state
    bit m_mode, m_src, m_pol, m_first, m_rprev;
    int m_div, m_cnt;

    always #2.5 clk = ~clk;

    pwm_irq_divider #(.DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .func_en(func_en), .carrier_unf(carrier_unf),
        .reload_sig(reload_sig), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .irq_pulse(irq_pulse)
    );

    task automatic model_reset();
        m_mode = 0; m_src = 0; m_pol = 0; m_first = 1; m_rprev = 0;
        m_div = 0; m_cnt = 0;
    endtask

    function automatic int limit_of(int dv, bit first);
        int eff = (dv == 0) ? 1 : dv;
        if (first && eff > 1) return eff - 1;
        return eff;
    endfunction

    task automatic model_step(input bit en, input bit unf, input bit rel,
                              input bit we, input bit sel, input int data,
                              output bit exp);
        bit e, rise, fall;
        exp  = 0;
        rise = rel && !m_rprev;
        fall = !rel && m_rprev;
        if (!en)                 e = 0;
        else if (m_mode && m_src) e = m_pol ? fall : rise;
        else                     e = unf;
        m_rprev = rel;
        if (we && !sel && !m_src) begin
            m_div = data; m_cnt = 0; m_first = 1;
        end else if (e) begin
            if (m_cnt + 1 >= limit_of(m_div, m_first)) begin
                exp = 1; m_cnt = 0; m_first = 0;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
        if (we && sel) begin
            m_mode = data[0]; m_src = data[1]; m_pol = data[2];
        end
    endtask

    task automatic cyc(input bit en, input bit unf, input bit rel,
                       input bit we, input bit sel, input int data);
        bit exp;
        func_en = en; carrier_unf = unf; reload_sig = rel;
        wr_en = we; wr_sel = sel; wr_data = data[DIV_W-1:0];
        rel_lvl = rel;
        model_step(en, unf, rel, we, sel, data, exp);
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (irq_pulse !== exp) begin
            fails++;
            $display("FAIL %s: irq_pulse=%0b expected=%0b at %0t", cur_req, irq_pulse, exp, $time);
        end
    endtask

    task automatic wr_div(input int n);   cyc(1, 0, rel_lvl, 1, 0, n); endtask
    task automatic wr_ctl(input bit mode, input bit src, input bit pol);
        cyc(1, 0, rel_lvl, 1, 1, {29'd0, pol, src, mode});
    endtask
    task automatic idle(input int k);
        for (int i = 0; i < k; i++) cyc(1, 0, rel_lvl, 0, 0, 0);
    endtask
    task automatic unf_pulses(input int k, input bit toggle_rel);
        for (int i = 0; i < k; i++) begin
            cyc(1, 1, toggle_rel ? ~rel_lvl : rel_lvl, 0, 0, 0);
            cyc(1, 0, rel_lvl, 0, 0, 0);
        end
    endtask
    task automatic rel_toggles(input int k, input bit with_unf);
        for (int i = 0; i < k; i++) begin
            cyc(1, with_unf, ~rel_lvl, 0, 0, 0);
            cyc(1, with_unf, rel_lvl, 0, 0, 0);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: all requirements, actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        checks++;
        if (irq_pulse !== 1'b0) begin
            fails++;
            $display("FAIL R1: irq_pulse=%0b expected=0 in reset", irq_pulse);
        end
        rst_n = 1'b1;

        // R1 / R6: reset divide value 0 acts as 1
        cur_req = "R1";  unf_pulses(4, 0);
        cur_req = "R6";  wr_div(1); unf_pulses(3, 0);
        wr_div(0); unf_pulses(3, 1);

        // R2 / R5: basic mode, n=4, reload toggles and src/pol ignored
        cur_req = "R5";  wr_div(4); unf_pulses(12, 1);
        cur_req = "R2";  wr_ctl(0, 1, 1); unf_pulses(9, 1); rel_toggles(6, 0);
        wr_ctl(0, 0, 0);

        // R3: extended mode, underflow source then reload source
        cur_req = "R3";  wr_div(3); wr_ctl(1, 0, 0); unf_pulses(7, 1);
        wr_ctl(1, 1, 0); unf_pulses(6, 0); rel_toggles(8, 1);

        // R4: polarity selects falling edge, one count per change
        cur_req = "R4";  wr_ctl(1, 1, 1); rel_toggles(8, 0);
        cyc(1, 0, 1, 0, 0, 0); idle(4); cyc(1, 0, 0, 0, 0, 0); idle(3);

        // R8: divide writes ignored while src bit is 1
        cur_req = "R8";  wr_div(1); rel_toggles(8, 0);

        // R7: divide write restarts count and drops same-cycle event
        cur_req = "R7";  wr_ctl(0, 0, 0); wr_div(5); unf_pulses(3, 0);
        cyc(1, 1, rel_lvl, 1, 0, 3); unf_pulses(6, 0);
        wr_div(2); unf_pulses(1, 0); wr_div(2); unf_pulses(4, 0);

        // R9: disabled block holds count and drops reload edges
        cur_req = "R9";  wr_div(3); unf_pulses(1, 0);
        for (int i = 0; i < 6; i++) cyc(0, 1, ~rel_lvl, 0, 0, 0);
        unf_pulses(5, 0);
        wr_ctl(1, 1, 0);
        for (int i = 0; i < 6; i++) cyc(0, 0, ~rel_lvl, 0, 0, 0);
        rel_toggles(6, 0); wr_ctl(0, 0, 0);

        // R10: back-to-back events with n=2, pulse width one cycle
        cur_req = "R10"; wr_div(2);
        for (int i = 0; i < 8; i++) cyc(1, 1, rel_lvl, 0, 0, 0);
        idle(3);

        // random mix
        cur_req = "R5";
        for (int i = 0; i < 4000; i++) begin
            bit en, unf, rel, we, sel;
            int data;
            en   = ($urandom % 16) != 0;
            unf  = ($urandom % 3) == 0;
            rel  = (($urandom % 4) == 0) ? ~rel_lvl : rel_lvl;
            we   = ($urandom % 40) == 0;
            sel  = $urandom % 2;
            data = sel ? int'($urandom % 8) : int'($urandom % 6);
            cyc(en, unf, rel, we, sel, data);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule